// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block moves one full 256-byte page of CPU-side memory into an 8-bit-addressed sprite attribute store. Software starts a copy with a single store to a fixed register address. The written byte becomes the upper byte of the source address, and the lower byte sweeps from 0 to 255. From the first cycle of a copy until its last store, the engine raises a stall line so that the CPU gives up the memory bus.

The engine is paced by a free-running parity input that reports whether the current global cycle count is odd. A new copy first waits until it has seen an odd cycle, and no data moves during that wait. After that, each even cycle fetches one byte from the source bus into a holding register. Each odd cycle stores the held byte at the current offset and advances the offset. The copy ends when the offset wraps back to zero, and the engine is then ready to start again.

Top module: `sprite_page_dma`

## Requirements
- R1: A synchronous active-high reset leaves the engine idle: `stall`, `src_rd` and `dst_we` are low in the cycle after a reset edge.
- R2: While idle, a cycle with `reg_we` high and `reg_addr` equal to parameter `REG_ADDR` starts a copy, so `stall` is high from the next cycle. A write to any other address has no effect.
- R3: Every fetch presents `src_addr` = {page, offset}: the written byte in bits 15:8 and the current offset in bits 7:0. The offset is 0 for the first fetch.
- R4: A copy moves no data until it has spent one busy cycle with `cyc_odd` = 1. The first fetch therefore comes in busy cycle 1 if the first busy cycle is odd, and in busy cycle 2 if it is even (counting the first busy cycle as 0).
- R5: Once aligned, each busy cycle with `cyc_odd` = 0 pulses `src_rd` for that one cycle and captures `src_data` in the same cycle.
- R6: Once aligned, each busy cycle with `cyc_odd` = 1 pulses `dst_we` for one cycle. It drives `dst_data` with the byte fetched in the previous cycle and `dst_addr` with the current offset, then adds 1 to the offset modulo 256.
- R7: A copy makes exactly 256 stores, to offsets 0 through 255 in rising order. `stall` falls in the cycle after the store to offset 255.
- R8: `stall` is high in every cycle of a copy, including the alignment cycles. While `stall` is low, `src_rd` and `dst_we` stay low.
- R9: A copy keeps `stall` high for 513 cycles if its first busy cycle is odd, and for 514 cycles if it is even.
- R10: A register write that arrives during a copy is ignored. The page and offset in use are unchanged.
- R11: A reset during a copy stops it at once. The next copy starts again with alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_odd | input | 1 | 1 when the current global cycle count is odd |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | 16 | CPU register write address |
| reg_wdata | input | 8 | CPU register write data (source page) |
| stall | output | 1 | Copy in progress; CPU must stall |
| src_rd | output | 1 | Source read request, one cycle |
| src_addr | output | 16 | Source read address |
| src_data | input | 8 | Source read data, sampled in the request cycle |
| dst_we | output | 1 | Destination write strobe, one cycle |
| dst_addr | output | 8 | Destination write offset |
| dst_data | output | 8 | Destination write data |

## Verification
The bench starts copies whose first busy cycle falls on each parity. An engine that skipped alignment, or that left alignment on the wrong parity, would fetch a cycle early or late and give a copy of the wrong length. The bench writes the register again in the middle of a copy, where an engine that reloaded the page would send bytes from the wrong page. It also resets in the middle of a copy, where an engine that kept its alignment flag cleared would start the next copy without waiting. The end of the copy is checked by exact store count and offset order, which catches both an early stop and a run past the wrap.

// File: rtl/sprdma_pkg.sv
package sprdma_pkg;
  localparam int PAGE_W = 8;
  localparam int OFS_W  = 8;
  localparam int SRC_AW = PAGE_W + OFS_W;
  localparam int DATA_W = 8;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [SRC_AW-1:0] src_addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ALIGN = 2'd1,
    PH_FETCH = 2'd2,
    PH_STORE = 2'd3
  } phase_e;

  // Source address: page in the upper bits, offset in the lower bits.
  function automatic src_addr_t form_src(input page_t pg, input ofs_t ofs);
    return {pg, ofs};
  endfunction

  // Offset advance with natural wrap.
  function automatic ofs_t bump_ofs(input ofs_t ofs);
    return ofs + ofs_t'(1);
  endfunction

  // True when the offset is the final one of a page.
  function automatic logic is_last_ofs(input ofs_t ofs);
    return &ofs;
  endfunction
endpackage

// File: rtl/sprdma_seq.sv
module sprdma_seq
  import sprdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   cyc_odd,
  input  logic   last,
  output logic   busy,
  output phase_e phase,
  output logic   fetch_evt,
  output logic   store_evt,
  output logic   done_evt
);
  logic busy_q;
  logic align_q;

  always_comb begin
    if (!busy_q)      phase = PH_IDLE;
    else if (align_q) phase = PH_ALIGN;
    else if (cyc_odd) phase = PH_STORE;
    else              phase = PH_FETCH;
  end

  assign fetch_evt = (phase == PH_FETCH);
  assign store_evt = (phase == PH_STORE);
  assign done_evt  = store_evt && last;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      align_q <= 1'b1;
    end else if (!busy_q) begin
      if (start) busy_q <= 1'b1;
    end else begin
      if (align_q && cyc_odd) align_q <= 1'b0;
      if (done_evt) begin
        busy_q  <= 1'b0;
        align_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sprdma_ptr.sv
module sprdma_ptr
  import sprdma_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  page_t load_page,
  input  logic  step,
  output page_t page,
  output ofs_t  ofs,
  output logic  last
);
  page_t page_q;
  ofs_t  ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (load) begin
      page_q <= load_page;
      ofs_q  <= '0;
    end else if (step) begin
      ofs_q  <= bump_ofs(ofs_q);
    end
  end

  assign page = page_q;
  assign ofs  = ofs_q;
  assign last = is_last_ofs(ofs_q);
endmodule

// File: rtl/sprdma_latch.sv
module sprdma_latch
  import sprdma_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  capture,
  input  byte_t din,
  output byte_t dout
);
  byte_t hold_q;

  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (capture) hold_q <= din;
  end

  assign dout = hold_q;
endmodule

// File: rtl/sprite_page_dma.sv
module sprite_page_dma
  import sprdma_pkg::*;
#(
  parameter logic [SRC_AW-1:0] REG_ADDR = 16'h2F80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_odd,
  input  logic              reg_we,
  input  logic [SRC_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              stall,
  output logic              src_rd,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic              dst_we,
  output logic [OFS_W-1:0]  dst_addr,
  output logic [DATA_W-1:0] dst_data
);
  logic   busy;
  phase_e phase;
  logic   fetch_evt;
  logic   store_evt;
  logic   done_evt;
  logic   start_evt;
  logic   last;
  page_t  page;
  ofs_t   ofs;
  byte_t  held;

  // Register writes are accepted only while idle.
  assign start_evt = reg_we && (reg_addr == REG_ADDR) && !busy;

  sprdma_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_evt),
    .cyc_odd   (cyc_odd),
    .last      (last),
    .busy      (busy),
    .phase     (phase),
    .fetch_evt (fetch_evt),
    .store_evt (store_evt),
    .done_evt  (done_evt)
  );

  sprdma_ptr u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (start_evt),
    .load_page (reg_wdata),
    .step      (store_evt),
    .page      (page),
    .ofs       (ofs),
    .last      (last)
  );

  sprdma_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (fetch_evt),
    .din     (src_data),
    .dout    (held)
  );

  assign stall    = busy;
  assign src_rd   = fetch_evt;
  assign src_addr = form_src(page, ofs);
  assign dst_we   = store_evt;
  assign dst_addr = ofs;
  assign dst_data = held;
endmodule

// File: rtl/sprdma_chk.sv
module sprdma_chk
  import sprdma_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cyc_odd,
  input logic              start_evt,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              stall,
  input logic              src_rd,
  input logic [SRC_AW-1:0] src_addr,
  input logic [DATA_W-1:0] src_data,
  input logic              dst_we,
  input logic [OFS_W-1:0]  dst_addr,
  input logic [DATA_W-1:0] dst_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !stall |-> (!src_rd && !dst_we)); // R8

  AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> (stall && !cyc_odd)); // R5

  AST_STORE_ODD: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> (stall && cyc_odd)); // R6

  AST_STORE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    dst_we |-> ($past(src_rd) && dst_data == $past(src_data))); // R6

  AST_OFS_STEP: assert property (@(posedge clk) disable iff (rst)
    (dst_we && !(&dst_addr)) |=>
      (stall && src_addr[OFS_W-1:0] == $past(dst_addr) + OFS_W'(1))); // R6

  AST_WRAP_END: assert property (@(posedge clk) disable iff (rst)
    (dst_we && (&dst_addr)) |=> !stall); // R7

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (stall && !src_rd && !dst_we &&
                   src_addr == {$past(reg_wdata), OFS_W'(0)})); // R4

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> $stable(src_addr[SRC_AW-1:OFS_W])); // R10
endmodule

bind sprite_page_dma sprdma_chk u_sprdma_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_odd   (cyc_odd),
  .start_evt (start_evt),
  .reg_wdata (reg_wdata),
  .stall     (stall),
  .src_rd    (src_rd),
  .src_addr  (src_addr),
  .src_data  (src_data),
  .dst_we    (dst_we),
  .dst_addr  (dst_addr),
  .dst_data  (dst_data)
);

// File: tb/test_sprite_page_dma.sv
`timescale 1ns/1ps
module test_sprite_page_dma;
  localparam logic [15:0] REG = 16'h2F80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_odd = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        stall, src_rd, dst_we;
  logic [15:0] src_addr;
  logic [7:0]  src_data, dst_addr, dst_data;

  int n_tests = 0;
  int n_fail  = 0;
  int gcnt    = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[15:8] ^ (a[7:0] * 8'd13 + 8'd5);
  endfunction

  assign src_data = src_byte(src_addr);

  sprite_page_dma #(.REG_ADDR(REG)) i_sprite_page_dma (
    .clk(clk), .rst(rst), .cyc_odd(cyc_odd), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stall(stall),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
    .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: flags as integers, expected stores as queues.
  int m_busy = 0, m_wait = 1, m_page = 0, m_cnt = 0;
  int q_ofs[$];
  int q_dat[$];

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_wait = 1; m_page = 0; m_cnt = 0;
      q_ofs.delete(); q_dat.delete();
    end else if (m_busy != 0) begin
      if (m_wait != 0) begin
        if (cyc_odd) m_wait = 0;
      end else if (cyc_odd) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 256) begin
          m_busy = 0; m_wait = 1; m_cnt = 0;
        end
      end
    end else if (reg_we && reg_addr == REG) begin
      m_page = int'(reg_wdata);
      m_cnt  = 0;
      m_busy = 1;
      for (int i = 0; i < 256; i++) begin
        q_ofs.push_back(i);
        q_dat.push_back(int'(src_byte(16'(m_page * 256 + i))));
      end
    end
  end

  // Per-cycle comparison, away from the clock edge.
  int run_len = 0, first_rd = -1, start_par = 0, n_st = 0;
  always @(negedge clk) begin
    #1;
    if (rst) begin
      run_len = 0;
    end else begin
      bit e_rd, e_we;
      e_rd = (m_busy != 0) && (m_wait == 0) && !cyc_odd;
      e_we = (m_busy != 0) && (m_wait == 0) && cyc_odd;
      chk(stall === (m_busy != 0), "R8 stall level", int'(stall), m_busy);
      chk(src_rd === e_rd, "R5 fetch pulse", int'(src_rd), int'(e_rd));
      chk(dst_we === e_we, "R6 store pulse", int'(dst_we), int'(e_we));
      if (src_rd && e_rd)
        chk(int'(src_addr) == m_page * 256 + m_cnt, "R3 source address",
            int'(src_addr), m_page * 256 + m_cnt);
      if (dst_we) begin
        if (q_ofs.size() == 0) chk(1'b0, "R7 store beyond page", int'(dst_addr), -1);
        else begin
          int eo, ed;
          eo = q_ofs.pop_front();
          ed = q_dat.pop_front();
          chk(int'(dst_addr) == eo, "R6 store offset", int'(dst_addr), eo);
          chk(int'(dst_data) == ed, "R6 store data", int'(dst_data), ed);
        end
      end
      if (stall) begin
        if (run_len == 0) begin
          start_par = int'(cyc_odd); first_rd = -1; n_st = 0;
        end
        if (src_rd && first_rd < 0) first_rd = run_len;
        if (dst_we) n_st++;
        run_len++;
      end else if (run_len > 0) begin
        chk(run_len == (start_par != 0 ? 513 : 514), "R9 copy length",
            run_len, start_par != 0 ? 513 : 514);
        chk(first_rd == (start_par != 0 ? 1 : 2), "R4 first fetch after alignment",
            first_rd, start_par != 0 ? 1 : 2);
        chk(n_st == 256, "R7 store count", n_st, 256);
        chk(q_ofs.size() == 0, "R7 all offsets stored", q_ofs.size(), 0);
        run_len = 0;
      end
    end
  end

  task automatic tick(input bit r, input bit we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    gcnt++;
    cyc_odd   = gcnt[0];
    rst       = r;
    reg_we    = we;
    reg_addr  = a;
    reg_wdata = d;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  // First busy cycle parity: want_odd.
  task automatic start_copy(input logic [7:0] pg, input bit want_odd);
    while (((gcnt + 2) % 2) != int'(want_odd)) idle();
    tick(1'b0, 1'b1, REG, pg);
  endtask

  task automatic wait_done();
    do begin
      idle();
      #1;
    end while (stall);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) tick(1'b1, 1'b0, 16'h0000, 8'h00);
    #1;
    chk(stall == 1'b0 && src_rd == 1'b0 && dst_we == 1'b0, "R1 reset idle",
        int'({stall, src_rd, dst_we}), 0);
    idle();

    // R2: wrong address and missing strobe do nothing.
    tick(1'b0, 1'b1, REG + 16'h0001, 8'h33);
    tick(1'b0, 1'b0, REG, 8'h34);
    idle();
    #1;
    chk(stall == 1'b0, "R2 other write ignored", int'(stall), 0);

    // R2 R9: copy whose first busy cycle is odd.
    start_copy(8'h12, 1'b1);
    idle();
    #1;
    chk(stall == 1'b1, "R2 start raises stall", int'(stall), 1);
    wait_done();

    // R9: first busy cycle even.
    start_copy(8'hA7, 1'b0);
    wait_done();

    // R10: second register write in mid copy is ignored.
    start_copy(8'h21, 1'b1);
    repeat (100) idle();
    tick(1'b0, 1'b1, REG, 8'h99);
    repeat (3) idle();
    #1;
    chk(src_addr[15:8] == 8'h21, "R10 page kept", int'(src_addr[15:8]), 8'h21);
    wait_done();

    // R11: reset during a copy, then a fresh copy.
    start_copy(8'h40, 1'b0);
    repeat (37) idle();
    tick(1'b1, 1'b0, 16'h0000, 8'h00);
    idle();
    #1;
    chk(stall == 1'b0, "R11 reset aborts copy", int'(stall), 0);
    start_copy(8'h41, 1'b0);
    wait_done();

    // Back-to-back copy with page 0xFF.
    start_copy(8'hFF, 1'b1);
    wait_done();
    repeat (4) idle();
    finish_run();
  end
endmodule